// File: doc/BRIEF.md
# Atomic Event Interference Monitor

This block watches a multi-address atomic event inside a processor core. A locked load opens the event when none is open and records its own PC as the point where execution restarts. Locked loads and locked prefetches then enter their cache lines into a small monitor table that sits beside the miss buffer. Every external coherence snoop is compared against the monitored lines, and a hit marks the event as interfered. The final locked store closes the event. It commits when no interference was seen. Otherwise it aborts and asks the front end to fetch again from the recorded restart point.

A branch-on-interference query reports the current interference state and moves the restart point to a new PC carried with the query. No bus is locked and there is no single-address reservation. Interference is detected only through snoop hits on the monitored line set.

Request encoding on `req_kind_i`: 0 = locked load, 1 = locked prefetch, 2 = locked store, 3 = interference query. A request is present only when `req_valid_i` is 1.

Top module: `atomic_intf_monitor`

## Requirements
- R1: After synchronous reset, `commit_o`, `abort_o`, `redir_valid_o`, `intf_o` and `query_hit_o` are 0 and `redir_pc_o` is 0.
- R2: A locked load (kind 0) while no event is open starts an event and captures that request's PC as the restart point. Later loads in the same event do not change the restart point.
- R3: Within an open event, locked loads (kind 0) and locked prefetches (kind 1) enter the 64-byte line of their address (address bits above bit 5) into the table. A valid snoop to any byte of a monitored line sets `intf_o` in the next cycle. A snoop to an unmonitored line does not set it.
- R4: Once set, `intf_o` stays at 1 until the event ends.
- R5: A locked store (kind 2) with no interference pulses `commit_o` for one cycle, in the cycle after the store. `abort_o` and `redir_valid_o` stay 0.
- R6: A locked store while the event is interfered pulses `abort_o` and `redir_valid_o` in the cycle after the store, with `redir_pc_o` equal to the restart point, and does not commit. A snoop hit arriving in the same cycle as the store also counts as interference.
- R7: A query (kind 3) during an open event drives `query_hit_o` in that same cycle with the current interference flag. It also replaces the restart point with the query's PC.
- R8: A snoop in the same cycle as a locked load to the same line counts as interference.
- R9: The table holds 8 distinct lines. A repeated access to a line already present takes no entry. An access that needs a ninth entry sets interference.
- R10: When an event ends, whether by commit or by abort, the monitored lines, the flag and the restart point are cleared. `intf_o` reads 0 the cycle after the store, and old lines no longer match snoops.
- R11: Outside an open event, a locked prefetch is ignored, a locked store commits plainly, and a query returns 0 without effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Locked-access request present |
| req_kind_i | input | 2 | 0 load, 1 prefetch, 2 store, 3 query |
| req_addr_i | input | ADDR_W | Byte address of the locked access |
| req_pc_i | input | PC_W | PC of the request (restart or alternate point) |
| snoop_valid_i | input | 1 | External coherence snoop present |
| snoop_addr_i | input | ADDR_W | Byte address of the snoop |
| commit_o | output | 1 | Locked store commits (one-cycle pulse) |
| abort_o | output | 1 | Locked store suppressed (one-cycle pulse) |
| redir_valid_o | output | 1 | Fetch redirect request |
| redir_pc_o | output | PC_W | Redirect target PC |
| intf_o | output | 1 | Current interference flag |
| query_hit_o | output | 1 | Query answer: interference seen |

## Verification
The main function is exercised with four kinds of pattern:
- Clean events commit, which shows that loads alone never trigger an abort.
- Snoops to a monitored line at an offset inside the line, and to an unrelated line, separate line-granular matching from exact or absent matching.
- Snoops landing in the same cycle as a load or as the final store show whether the comparison covers entries still being written.
- A fill of eight distinct lines plus a repeat, then a ninth line, separates duplicate merging from overflow.

Queries before and after a hit, followed by an abort, show whether the alternate PC replaces the original restart point.

// File: rtl/aem_pkg.sv
package aem_pkg;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_PREF  = 2'd1,
        ACC_STORE = 2'd2,
        ACC_QUERY = 2'd3
    } acc_kind_e;

    typedef struct packed {
        logic commit;
        logic abort;
    } outcome_t;

endpackage

// File: rtl/aem_line_table.sv
module aem_line_table #(
    parameter int ENTRIES = 8,
    parameter int TAG_W   = 26
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear_i,
    input  logic             ins_i,
    input  logic [TAG_W-1:0] ins_tag_i,
    input  logic             snoop_valid_i,
    input  logic [TAG_W-1:0] snoop_tag_i,
    output logic             snoop_hit_o,
    output logic             overflow_o
);
    logic [ENTRIES-1:0] valid_q;
    logic [TAG_W-1:0]   tag_q [ENTRIES];
    logic [ENTRIES-1:0] snoop_match;
    logic [ENTRIES-1:0] ins_match;
    logic [ENTRIES-1:0] alloc_oh;
    logic               free_found;
    logic               present;

    always_comb begin
        alloc_oh   = '0;
        free_found = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (!valid_q[i] && !free_found) begin
                alloc_oh[i] = 1'b1;
                free_found  = 1'b1;
            end
        end
    end

    assign present     = |ins_match;
    assign overflow_o  = ins_i && !present && !free_found;
    assign snoop_hit_o = snoop_valid_i &&
                         ((|snoop_match) || (ins_i && (ins_tag_i == snoop_tag_i)));

    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        assign snoop_match[g] = valid_q[g] && (tag_q[g] == snoop_tag_i);
        assign ins_match[g]   = valid_q[g] && (tag_q[g] == ins_tag_i);

        always_ff @(posedge clk) begin
            if (rst || clear_i) begin
                valid_q[g] <= 1'b0;
                tag_q[g]   <= '0;
            end else if (ins_i && !present && alloc_oh[g]) begin
                valid_q[g] <= 1'b1;
                tag_q[g]   <= ins_tag_i;
            end
        end
    end

    // R9
    table_full_chk: assert property (@(posedge clk) disable iff (rst)
        overflow_o |-> (&valid_q));

    // R10
    table_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clear_i |=> (valid_q == '0));

endmodule

// File: rtl/aem_event_ctrl.sv
module aem_event_ctrl
    import aem_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid_i,
    input  acc_kind_e       req_kind_i,
    input  logic [PC_W-1:0] req_pc_i,
    input  logic            snoop_hit_i,
    input  logic            overflow_i,
    output logic            ins_o,
    output logic            clear_o,
    output logic            commit_o,
    output logic            abort_o,
    output logic            redir_valid_o,
    output logic [PC_W-1:0] redir_pc_o,
    output logic            intf_o,
    output logic            query_hit_o
);
    logic            active_q;
    logic            flag_q;
    logic [PC_W-1:0] cp_q;
    outcome_t        out_q;
    logic            redir_q;
    logic [PC_W-1:0] redir_pc_q;

    logic is_load, is_pref, is_store, is_query, intf_now;

    assign is_load  = req_valid_i && (req_kind_i == ACC_LOAD);
    assign is_pref  = req_valid_i && (req_kind_i == ACC_PREF);
    assign is_store = req_valid_i && (req_kind_i == ACC_STORE);
    assign is_query = req_valid_i && (req_kind_i == ACC_QUERY);

    assign ins_o    = is_load || (is_pref && active_q);
    assign clear_o  = is_store && active_q;
    assign intf_now = flag_q || snoop_hit_i || overflow_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q   <= 1'b0;
            flag_q     <= 1'b0;
            cp_q       <= '0;
            out_q      <= '0;
            redir_q    <= 1'b0;
            redir_pc_q <= '0;
        end else begin
            out_q      <= '0;
            redir_q    <= 1'b0;
            redir_pc_q <= '0;
            if (is_store) begin
                if (active_q && intf_now) begin
                    out_q.abort <= 1'b1;
                    redir_q     <= 1'b1;
                    redir_pc_q  <= cp_q;
                end else begin
                    out_q.commit <= 1'b1;
                end
                active_q <= 1'b0;
                flag_q   <= 1'b0;
                cp_q     <= '0;
            end else begin
                if (is_load && !active_q) begin
                    active_q <= 1'b1;
                    cp_q     <= req_pc_i;
                end
                if (is_query && active_q) begin
                    cp_q <= req_pc_i;
                end
                if ((active_q || is_load) && (snoop_hit_i || overflow_i)) begin
                    flag_q <= 1'b1;
                end
            end
        end
    end

    assign commit_o      = out_q.commit;
    assign abort_o       = out_q.abort;
    assign redir_valid_o = redir_q;
    assign redir_pc_o    = redir_pc_q;
    assign intf_o        = flag_q;
    assign query_hit_o   = is_query && active_q && flag_q;

    // R2
    cp_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (is_load && !active_q) |=> (redir_pc_q == '0 && cp_q == $past(req_pc_i)));

    // R3
    hit_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (snoop_hit_i && !is_store) |=> intf_o);

    // R4
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (intf_o && !is_store) |=> intf_o);

    // R5
    store_commit_chk: assert property (@(posedge clk) disable iff (rst)
        (is_store && !flag_q && !snoop_hit_i) |=> (commit_o && !abort_o && !redir_valid_o));

    // R6
    store_abort_chk: assert property (@(posedge clk) disable iff (rst)
        (is_store && active_q && flag_q) |=> (abort_o && redir_valid_o && !commit_o));

    // R10
    end_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (is_store && active_q) |=> (!active_q && !intf_o && cp_q == '0));

endmodule

// File: rtl/atomic_intf_monitor.sv
module atomic_intf_monitor
    import aem_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int PC_W       = 32,
    parameter int LINE_BYTES = 64,
    parameter int ENTRIES    = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid_i,
    input  logic [1:0]        req_kind_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [PC_W-1:0]   req_pc_i,
    input  logic              snoop_valid_i,
    input  logic [ADDR_W-1:0] snoop_addr_i,
    output logic              commit_o,
    output logic              abort_o,
    output logic              redir_valid_o,
    output logic [PC_W-1:0]   redir_pc_o,
    output logic              intf_o,
    output logic              query_hit_o
);
    localparam int OFF_W = $clog2(LINE_BYTES);
    localparam int TAG_W = ADDR_W - OFF_W;

    logic ins, clear, snoop_hit, overflow;

    aem_event_ctrl #(.PC_W(PC_W)) u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .req_valid_i   (req_valid_i),
        .req_kind_i    (acc_kind_e'(req_kind_i)),
        .req_pc_i      (req_pc_i),
        .snoop_hit_i   (snoop_hit),
        .overflow_i    (overflow),
        .ins_o         (ins),
        .clear_o       (clear),
        .commit_o      (commit_o),
        .abort_o       (abort_o),
        .redir_valid_o (redir_valid_o),
        .redir_pc_o    (redir_pc_o),
        .intf_o        (intf_o),
        .query_hit_o   (query_hit_o)
    );

    aem_line_table #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_table (
        .clk           (clk),
        .rst           (rst),
        .clear_i       (clear),
        .ins_i         (ins),
        .ins_tag_i     (req_addr_i[ADDR_W-1:OFF_W]),
        .snoop_valid_i (snoop_valid_i),
        .snoop_tag_i   (snoop_addr_i[ADDR_W-1:OFF_W]),
        .snoop_hit_o   (snoop_hit),
        .overflow_o    (overflow)
    );

    // R6
    redir_pair_chk: assert property (@(posedge clk) disable iff (rst)
        redir_valid_o |-> (abort_o && !commit_o));

endmodule

// File: tb/tb_atomic_intf_monitor.sv
module tb_atomic_intf_monitor;
    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] K_LD = 2'd0, K_PF = 2'd1, K_ST = 2'd2, K_QY = 2'd3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid_i = 1'b0;
    logic [1:0]  req_kind_i = '0;
    logic [31:0] req_addr_i = '0;
    logic [31:0] req_pc_i = '0;
    logic        snoop_valid_i = 1'b0;
    logic [31:0] snoop_addr_i = '0;
    logic        commit_o, abort_o, redir_valid_o, intf_o, query_hit_o;
    logic [31:0] redir_pc_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    bit          exp_abort_q [$];
    logic [31:0] exp_pc_q    [$];
    string       exp_req_q   [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    atomic_intf_monitor dut (
        .clk(clk), .rst(rst),
        .req_valid_i(req_valid_i), .req_kind_i(req_kind_i),
        .req_addr_i(req_addr_i), .req_pc_i(req_pc_i),
        .snoop_valid_i(snoop_valid_i), .snoop_addr_i(snoop_addr_i),
        .commit_o(commit_o), .abort_o(abort_o),
        .redir_valid_o(redir_valid_o), .redir_pc_o(redir_pc_o),
        .intf_o(intf_o), .query_hit_o(query_hit_o)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic drive(input bit rv, input logic [1:0] k, input logic [31:0] a,
                         input logic [31:0] pc, input bit sv, input logic [31:0] sa);
        @(negedge clk);
        req_valid_i   = rv;
        req_kind_i    = k;
        req_addr_i    = a;
        req_pc_i      = pc;
        snoop_valid_i = sv;
        snoop_addr_i  = sa;
    endtask

    task automatic idle();
        drive(1'b0, K_LD, '0, '0, 1'b0, '0);
    endtask

    task automatic acc(input logic [1:0] k, input logic [31:0] a, input logic [31:0] pc);
        drive(1'b1, k, a, pc, 1'b0, '0);
    endtask

    task automatic snoop(input logic [31:0] sa);
        drive(1'b0, K_LD, '0, '0, 1'b1, sa);
    endtask

    // driver side of the scoreboard: push expectation, then issue the store
    task automatic store(input logic [31:0] a, input bit sv, input logic [31:0] sa,
                         input bit ab, input logic [31:0] pc, input string req);
        exp_abort_q.push_back(ab);
        exp_pc_q.push_back(ab ? pc : 32'h0);
        exp_req_q.push_back(req);
        drive(1'b1, K_ST, a, 32'h0, sv, sa);
        idle();
    endtask

    task automatic query(input logic [31:0] pc, input bit exp_hit, input string req);
        acc(K_QY, 32'h0, pc);
        #1;
        chk(query_hit_o == exp_hit, req, query_hit_o, exp_hit);
    endtask

    // monitor side of the scoreboard
    always @(negedge clk) begin
        if (!rst && !done && (commit_o || abort_o || redir_valid_o)) begin
            if (exp_abort_q.size() == 0) begin
                chk(1'b0, "R5/R6 unexpected outcome", {commit_o, abort_o, redir_valid_o}, 0);
            end else begin
                bit          ab;
                logic [31:0] pc;
                string       rq;
                ab = exp_abort_q.pop_front();
                pc = exp_pc_q.pop_front();
                rq = exp_req_q.pop_front();
                chk(commit_o == !ab && abort_o == ab && redir_valid_o == ab && redir_pc_o == pc,
                    rq, {commit_o, abort_o, redir_valid_o, redir_pc_o},
                    {!ab, ab, ab, pc});
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk({commit_o, abort_o, redir_valid_o, intf_o, query_hit_o} == 5'b0 && redir_pc_o == 0,
            "R1", {commit_o, abort_o, redir_valid_o, intf_o, query_hit_o, redir_pc_o}, 0);

        // R5 clean event commits
        acc(K_LD, 32'h1000, 32'h100);
        acc(K_LD, 32'h2000, 32'h104);
        store(32'h2000, 1'b0, 0, 1'b0, 0, "R5 clean commit");
        chk(intf_o == 1'b0, "R5 flag after commit", intf_o, 0);

        // R2 R3 R6: unrelated snoop, then snoop inside a prefetched line
        acc(K_LD, 32'h3000, 32'h200);
        acc(K_PF, 32'h4000, 32'h204);
        snoop(32'h5000);
        idle();
        chk(intf_o == 1'b0, "R3 unrelated line", intf_o, 0);
        snoop(32'h4010);
        idle();
        chk(intf_o == 1'b1, "R3 prefetched line hit", intf_o, 1);
        acc(K_LD, 32'h6000, 32'h208);
        idle();
        chk(intf_o == 1'b1, "R4 flag sticky", intf_o, 1);
        store(32'h3000, 1'b0, 0, 1'b1, 32'h200, "R2 R6 abort to first load pc");
        chk(intf_o == 1'b0, "R10 flag cleared", intf_o, 0);

        // R10 old lines no longer monitored
        acc(K_LD, 32'h7000, 32'h300);
        snoop(32'h3000);
        idle();
        chk(intf_o == 1'b0, "R10 old line cleared", intf_o, 0);
        store(32'h7000, 1'b0, 0, 1'b0, 0, "R10 commit after clear");

        // R7 query replaces control point
        acc(K_LD, 32'h8000, 32'h400);
        query(32'h480, 1'b0, "R7 query before hit");
        snoop(32'h803F);
        idle();
        query(32'h500, 1'b1, "R7 query after hit");
        store(32'h8000, 1'b0, 0, 1'b1, 32'h500, "R7 abort to alternate pc");

        // R8 same-cycle snoop and load
        drive(1'b1, K_LD, 32'h9000, 32'h600, 1'b1, 32'h9020);
        idle();
        chk(intf_o == 1'b1, "R8 same-cycle hit", intf_o, 1);
        store(32'h9000, 1'b0, 0, 1'b1, 32'h600, "R8 abort");

        // R9 eight distinct lines plus a repeat: no overflow
        for (int i = 0; i < 8; i++) acc(K_LD, 32'hA000 + i * 64, 32'h700 + i * 4);
        acc(K_LD, 32'hA000, 32'h7F0);
        idle();
        chk(intf_o == 1'b0, "R9 repeat takes no entry", intf_o, 0);
        store(32'hA000, 1'b0, 0, 1'b0, 0, "R9 commit at full table");

        // R9 ninth distinct line overflows
        for (int i = 0; i < 9; i++) acc(K_LD, 32'hB000 + i * 64, 32'h800 + i * 4);
        idle();
        chk(intf_o == 1'b1, "R9 overflow sets flag", intf_o, 1);
        store(32'hB000, 1'b0, 0, 1'b1, 32'h800, "R9 overflow abort");

        // R11 prefetch, store and query outside an event
        acc(K_PF, 32'hC000, 32'h900);
        query(32'h904, 1'b0, "R11 query idle");
        acc(K_LD, 32'hD000, 32'h908);
        snoop(32'hC000);
        idle();
        chk(intf_o == 1'b0, "R11 idle prefetch ignored", intf_o, 0);
        store(32'hD000, 1'b0, 0, 1'b0, 0, "R11 commit");
        store(32'hE000, 1'b0, 0, 1'b0, 0, "R11 store without event");

        // R6 snoop in the store cycle
        acc(K_LD, 32'hF000, 32'hA00);
        store(32'hF000, 1'b1, 32'hF008, 1'b1, 32'hA00, "R6 store-cycle snoop");

        repeat (3) idle();
        chk(exp_abort_q.size() == 0, "R5/R6 missing outcomes", exp_abort_q.size(), 0);
        finish_run();
    end
endmodule